// File: doc/BRIEF.md
# Serial Configuration Write Port

This block is the receive-only serial front end of a four-voice wavetable synthesizer. A host drives an active-low select line, a serial clock and a data line. The block brings all three into the system clock domain and assembles bytes from them. It turns each framed transaction into single-cycle write strobes that the synthesizer's configuration storage consumes.

The first byte of a framed transaction picks a destination. Bits [3:2] of that byte choose the register class and bits [1:0] choose the voice. The payload bytes that follow are written to that destination. Each strobe carries a byte offset, which counts payload bytes from zero, so a wave table fills one entry per byte. A destination accepts only as many bytes as it holds, and any further bytes are dropped. Nothing is ever sent back to the host.

Top module: `spi_cfg_loader`

## Requirements
- R1: After reset, `wr_en_o` is 0 and `wr_class_o`, `wr_voice_o`, `wr_offset_o` and `wr_data_o` are all 0.
- R2: The first complete byte after the select line falls is taken as the address and produces no write strobe.
- R3: Addresses 0–3 (class code 0) select the 16-bit frequency step of voices 0–3. The first payload byte is the high half and is written with offset 0. The second is the low half and is written with offset 1.
- R4: Addresses 4–7 (class code 1) select the 256-entry wave table of voices 0–3. Payload byte n is written with offset n.
- R5: Addresses 8–11 (class code 2) select the left volume of voices 0–3. The byte is written with offset 0.
- R6: Addresses 12–15 (class code 3) select the right volume of voices 0–3. The byte is written with offset 0.
- R7: Payload bytes beyond a destination's size produce no strobe. The sizes are 2 bytes for frequency, 256 for a wave table and 1 for a volume.
- R8: When the address byte is 16 or above, no payload byte of that transaction produces a strobe.
- R9: Bits of an unfinished byte are discarded when the select line rises. The next transaction starts again with an address byte.
- R10: Data is sampled on falling serial-clock edges only, most significant bit first. Serial-clock activity while the select line is high writes nothing.
- R11: Each accepted payload byte gives exactly one strobe, one system clock wide. `wr_voice_o` equals the address bits [1:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, 100 MHz |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock from the host, idles high |
| mosi_i | input | 1 | Serial data from the host |
| csn_i | input | 1 | Active-low transaction select |
| wr_en_o | output | 1 | Write strobe, one cycle per accepted byte |
| wr_class_o | output | 2 | Register class: 0 frequency, 1 wave, 2 left volume, 3 right volume |
| wr_voice_o | output | 2 | Voice index |
| wr_offset_o | output | 8 | Byte offset inside the destination |
| wr_data_o | output | 8 | Payload byte |

## Verification
The hardest state to reach from the ports is a wave-table fill that runs past its last entry. Reaching it needs a single uninterrupted select window carrying 257 or more payload bytes. A directed transaction of 260 bytes drives offsets through 255 and checks that the final four bytes vanish. Dropping the select line partway through a byte, followed at once by a fresh transaction, checks that no stale bits leak into the next address. Random transactions mix valid and invalid addresses with varied payload lengths.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;
  typedef enum logic [1:0] {
    CL_FREQ  = 2'd0,
    CL_WAVE  = 2'd1,
    CL_VOL_L = 2'd2,
    CL_VOL_R = 2'd3
  } tgt_class_e;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_i,
  input  logic mosi_i,
  input  logic csn_i,
  output logic sclk_fall_o,
  output logic mosi_o,
  output logic cs_act_o
);
  // bit 0 serial clock, bit 1 data, bit 2 select; idle levels
  localparam logic [2:0] IDLE = 3'b101;

  logic [2:0] raw;
  logic [2:0] synced;
  logic       sclk_prev_q;

  assign raw = {csn_i, mosi_i, sclk_i};

  for (genvar g = 0; g < 3; g++) begin : g_chain
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {STAGES{IDLE[g]}};
      else        chain_q <= {chain_q[STAGES-2:0], raw[g]};
    end
    assign synced[g] = chain_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_prev_q <= 1'b1;
    else        sclk_prev_q <= synced[0];
  end

  assign sclk_fall_o = sclk_prev_q & ~synced[0];
  assign mosi_o      = synced[1];
  assign cs_act_o    = ~synced[2];
endmodule

// File: rtl/spi_byte_rx.sv
module spi_byte_rx #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act_i,
  input  logic              sclk_fall_i,
  input  logic              mosi_i,
  output logic              byte_vld_o,
  output logic [BYTE_W-1:0] byte_o
);
  localparam int CW = $clog2(BYTE_W);

  logic [BYTE_W-1:0] shift_q, shift_d, data_q, data_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic              vld_q, vld_d;

  always_comb begin
    shift_d = shift_q;
    cnt_d   = cnt_q;
    data_d  = data_q;
    vld_d   = 1'b0;
    if (!cs_act_i) begin
      cnt_d = '0;
    end else if (sclk_fall_i) begin
      shift_d = {shift_q[BYTE_W-2:0], mosi_i};
      cnt_d   = cnt_q + 1'b1;
      if (cnt_q == CW'(BYTE_W - 1)) begin
        vld_d  = 1'b1;
        data_d = {shift_q[BYTE_W-2:0], mosi_i};
        cnt_d  = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      cnt_q   <= '0;
      data_q  <= '0;
      vld_q   <= 1'b0;
    end else begin
      shift_q <= shift_d;
      cnt_q   <= cnt_d;
      data_q  <= data_d;
      vld_q   <= vld_d;
    end
  end

  assign byte_vld_o = vld_q;
  assign byte_o     = data_q;
endmodule

// File: rtl/spi_frame_dec.sv
module spi_frame_dec
  import spi_cfg_pkg::*;
#(
  parameter int NUM_VOICES  = 4,
  parameter int TABLE_DEPTH = 256,
  parameter int FREQ_BYTES  = 2,
  localparam int VW   = $clog2(NUM_VOICES),
  localparam int OFSW = $clog2(TABLE_DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cs_act_i,
  input  logic            byte_vld_i,
  input  logic [7:0]      byte_i,
  output logic            wr_en_o,
  output logic [1:0]      wr_class_o,
  output logic [VW-1:0]   wr_voice_o,
  output logic [OFSW-1:0] wr_offset_o,
  output logic [7:0]      wr_data_o
);
  localparam int IDXW     = $clog2(TABLE_DEPTH + 1);
  localparam int NUM_ADDR = 4 * NUM_VOICES;

  logic             have_addr_q, have_addr_d;
  logic             tgt_ok_q, tgt_ok_d;
  tgt_class_e       cls_q, cls_d;
  logic [VW-1:0]    voice_q, voice_d;
  logic [IDXW-1:0]  idx_q, idx_d, limit;
  logic             en_q, en_d;
  logic [OFSW-1:0]  ofs_q, ofs_d;
  logic [7:0]       dat_q, dat_d;

  always_comb begin
    case (cls_q)
      CL_FREQ: limit = IDXW'(FREQ_BYTES);
      CL_WAVE: limit = IDXW'(TABLE_DEPTH);
      default: limit = IDXW'(1);
    endcase
  end

  always_comb begin
    have_addr_d = have_addr_q;
    tgt_ok_d    = tgt_ok_q;
    cls_d       = cls_q;
    voice_d     = voice_q;
    idx_d       = idx_q;
    en_d        = 1'b0;
    ofs_d       = ofs_q;
    dat_d       = dat_q;
    if (!cs_act_i) begin
      have_addr_d = 1'b0;
      tgt_ok_d    = 1'b0;
    end else if (byte_vld_i) begin
      if (!have_addr_q) begin
        have_addr_d = 1'b1;
        tgt_ok_d    = (int'(byte_i) < NUM_ADDR);
        cls_d       = tgt_class_e'(byte_i[VW+1:VW]);
        voice_d     = byte_i[VW-1:0];
        idx_d       = '0;
      end else if (tgt_ok_q && (idx_q < limit)) begin
        en_d  = 1'b1;
        ofs_d = idx_q[OFSW-1:0];
        dat_d = byte_i;
        idx_d = idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_addr_q <= 1'b0;
      tgt_ok_q    <= 1'b0;
      cls_q       <= CL_FREQ;
      voice_q     <= '0;
      idx_q       <= '0;
      en_q        <= 1'b0;
      ofs_q       <= '0;
      dat_q       <= '0;
    end else begin
      have_addr_q <= have_addr_d;
      tgt_ok_q    <= tgt_ok_d;
      cls_q       <= cls_d;
      voice_q     <= voice_d;
      idx_q       <= idx_d;
      en_q        <= en_d;
      ofs_q       <= ofs_d;
      dat_q       <= dat_d;
    end
  end

  assign wr_en_o     = en_q;
  assign wr_class_o  = en_q ? cls_q : 2'd0;
  assign wr_voice_o  = en_q ? voice_q : '0;
  assign wr_offset_o = ofs_q;
  assign wr_data_o   = dat_q;
endmodule

// File: rtl/spi_cfg_loader.sv
module spi_cfg_loader #(
  parameter int NUM_VOICES  = 4,
  parameter int TABLE_DEPTH = 256,
  parameter int FREQ_BYTES  = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sclk_i,
  input  logic       mosi_i,
  input  logic       csn_i,
  output logic       wr_en_o,
  output logic [1:0] wr_class_o,
  output logic [1:0] wr_voice_o,
  output logic [7:0] wr_offset_o,
  output logic [7:0] wr_data_o
);
  logic       sclk_fall, mosi_s, cs_act, byte_vld;
  logic [7:0] byte_d;

  spi_pin_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk_i), .mosi_i(mosi_i), .csn_i(csn_i),
    .sclk_fall_o(sclk_fall), .mosi_o(mosi_s), .cs_act_o(cs_act)
  );

  spi_byte_rx #(.BYTE_W(8)) i_rx (
    .clk(clk), .rst_n(rst_n), .cs_act_i(cs_act), .sclk_fall_i(sclk_fall),
    .mosi_i(mosi_s), .byte_vld_o(byte_vld), .byte_o(byte_d)
  );

  spi_frame_dec #(
    .NUM_VOICES(NUM_VOICES), .TABLE_DEPTH(TABLE_DEPTH), .FREQ_BYTES(FREQ_BYTES)
  ) i_dec (
    .clk(clk), .rst_n(rst_n), .cs_act_i(cs_act), .byte_vld_i(byte_vld),
    .byte_i(byte_d), .wr_en_o(wr_en_o), .wr_class_o(wr_class_o),
    .wr_voice_o(wr_voice_o), .wr_offset_o(wr_offset_o), .wr_data_o(wr_data_o)
  );
endmodule

// File: rtl/spi_cfg_loader_chk.sv
module spi_cfg_loader_chk #(
  parameter int FREQ_BYTES = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_act,
  input logic       wr_en,
  input logic [1:0] wr_class,
  input logic [7:0] wr_offset
);
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en); // R11
  AST_FREQ_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_class == 2'd0) |-> (int'(wr_offset) < FREQ_BYTES)); // R3
  AST_VOL_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_class[1]) |-> (wr_offset == 8'd0)); // R7
  AST_WRITE_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(cs_act)); // R9
  AST_STROBE_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
    !$isunknown(wr_en)); // R1
endmodule

bind spi_cfg_loader spi_cfg_loader_chk #(.FREQ_BYTES(FREQ_BYTES)) i_chk (
  .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .wr_en(wr_en_o),
  .wr_class(wr_class_o), .wr_offset(wr_offset_o)
);

// File: tb/test_spi_cfg_loader.sv
module test_spi_cfg_loader;
  localparam int CLK_P = 10;
  localparam int HALF  = 4;

  logic clk, rst_n, sclk, mosi, csn;
  logic       wr_en;
  logic [1:0] wr_class, wr_voice;
  logic [7:0] wr_offset, wr_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [19:0] got [0:511];
  logic [19:0] exp [0:511];
  int          n_got, n_exp;
  logic [7:0]  pay [0:299];

  spi_cfg_loader i_spi_cfg_loader (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .mosi_i(mosi), .csn_i(csn),
    .wr_en_o(wr_en), .wr_class_o(wr_class), .wr_voice_o(wr_voice),
    .wr_offset_o(wr_offset), .wr_data_o(wr_data)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  always @(negedge clk) begin
    if (rst_n && wr_en && n_got < 512) begin
      got[n_got] = {wr_class, wr_voice, wr_offset, wr_data};
      n_got++;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // expected writes from the requirements
  task automatic build_exp(input logic [7:0] addr, input int n);
    int lim;
    n_exp = 0;
    if (addr >= 8'd16) return;
    lim = (addr[3:2] == 2'd0) ? 2 : (addr[3:2] == 2'd1) ? 256 : 1;
    for (int i = 0; i < n && i < lim; i++) begin
      exp[n_exp] = {addr[3:2], addr[1:0], 8'(i), pay[i]};
      n_exp++;
    end
  endtask

  task automatic send_bits(input logic [7:0] b, input int nb);
    for (int k = 7; k > 7 - nb; k--) begin
      mosi = b[k];
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
      repeat (HALF) @(negedge clk);
      sclk = 1'b1;
    end
  endtask

  task automatic txn(input string req, input logic [7:0] addr, input int n, input int partial);
    n_got = 0;
    build_exp(addr, n);
    csn = 1'b0;
    repeat (4) @(negedge clk);
    send_bits(addr, 8);
    for (int i = 0; i < n; i++) send_bits(pay[i], 8);
    if (partial > 0) send_bits(8'($urandom), partial);
    repeat (4) @(negedge clk);
    csn = 1'b1;
    repeat (12) @(negedge clk);
    check({req, " write count"}, n_got, n_exp);
    for (int i = 0; i < n_exp && i < n_got; i++)
      check({req, " write entry"}, got[i], exp[i]);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; sclk = 1'b1; mosi = 1'b0; csn = 1'b1; n_got = 0;
    repeat (5) @(negedge clk);
    // R1 reset state
    check("R1 strobe", wr_en, 0);
    check("R1 fields", {wr_class, wr_voice, wr_offset, wr_data}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R3 frequency high then low, R10 MSB first
    pay[0] = 8'h02; pay[1] = 8'h80;
    txn("R3", 8'd2, 2, 0);
    pay[0] = 8'hA5; pay[1] = 8'h3C; pay[2] = 8'hFF;
    txn("R7 R3 extra", 8'd0, 3, 0);
    // R2 address only
    txn("R2", 8'd4, 0, 0);
    // R4 full wave fill plus overrun (R7)
    for (int i = 0; i < 260; i++) pay[i] = 8'($urandom);
    txn("R4 R7 wave", 8'd7, 260, 0);
    // R5, R6
    pay[0] = 8'h77; pay[1] = 8'h11;
    txn("R5", 8'd9, 1, 0);
    txn("R6 R7", 8'd14, 2, 0);
    // R8 invalid addresses
    txn("R8", 8'd16, 3, 0);
    txn("R8", 8'hFF, 2, 0);
    // R9 partial byte then fresh transaction
    pay[0] = 8'h5A; pay[1] = 8'hC3;
    txn("R9 partial", 8'd5, 2, 5);
    pay[0] = 8'h9E; pay[1] = 8'h01;
    txn("R9 next", 8'd1, 2, 0);
    txn("R9 partial only", 8'd6, 0, 3);
    // R10 clock activity while deselected
    n_got = 0;
    for (int i = 0; i < 24; i++) send_bits(8'($urandom), 1);
    repeat (12) @(negedge clk);
    check("R10 idle clocks", n_got, 0);
    pay[0] = 8'h44;
    txn("R10 after idle", 8'd12, 1, 0);

    // random mix (R11 one strobe per byte)
    for (int it = 0; it < 40; it++) begin
      logic [7:0] a;
      int n;
      a = 8'($urandom_range(0, 17));
      n = $urandom_range(0, 5);
      for (int i = 0; i < n; i++) pay[i] = 8'($urandom);
      txn("R11 random", a, n, ($urandom_range(0, 3) == 0) ? $urandom_range(1, 7) : 0);
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule